// File: doc/BRIEF.md
# Compact Branch Resolution Unit

This block resolves the control transfer of one decoded 32-bit instruction per clock for a core that mixes compact branches (no delay slot, a forbidden slot after them) with older delayed branches. It receives the instruction word, both register operand values, bit 0 of the selected floating-point register, the current PC and a legacy-mode select. It decides whether the transfer is taken and computes the next PC. It also reports whether register 31 receives a link value, and whether the instruction owns a delay slot or a forbidden slot.

Several major opcodes are overloaded. The variant is chosen by comparing the two register numbers in the instruction: either field may be zero, the two may be equal, or one may be larger than the other. One pair of opcodes tests whether a signed 32-bit add of the operands overflows. Results are registered: they appear one clock after the instruction is presented, together with a valid strobe.

The instruction word uses opcode = bits 31:26, first register number (rs) = bits 25:21, second register number (rt) = bits 20:16. The offset field is the low 16, 21 or 26 bits.

Top module: `cbr_unit`

## Requirements
- R1: During reset (synchronous, rst_n low) all outputs are zero. Every instruction sampled with in_valid high at a rising edge produces its results with out_valid high after that edge. out_valid is low after any edge where in_valid was low.
- R2: Opcodes 6 and 7 with legacy_mode low and rt number nonzero are compact branches. With rs number 0 they link and are taken when rt value <= 0 (opcode 6) or > 0 (opcode 7). With rs number equal to rt number they link and are taken when rt value >= 0 or < 0. Otherwise they do not link and compare rs value against rt value unsigned: >= (opcode 6) or < (opcode 7).
- R3: Opcodes 22 and 23 with legacy_mode low and rt number nonzero select their variant the same way but never link. The zero tests on rt are <= 0 / >= 0 (opcode 22) and > 0 / < 0 (opcode 23), and the third variant is a signed rs >= rt (opcode 22) or rs < rt (opcode 23). With rt number 0 these opcodes make no transfer.
- R4: Opcodes 8 and 24 with legacy_mode low and rs number >= rt number are compact branches without link. Opcode 8 is taken when rs value + rt value overflows a signed 32-bit result. Opcode 24 is taken when that add does not overflow.
- R5: Opcodes 8 and 24 with legacy_mode low and rs number < rt number test equality. With rs number 0 they link and are taken on rt value == 0 (opcode 8) or != 0 (opcode 24). Otherwise they are taken on rs value == rt value or != without link.
- R6: A taken compact branch goes to PC + 4 + (sign-extended offset << 2). The offset is bits 15:0 for register tests, bits 20:0 for the rs zero tests of opcodes 54 and 62, and bits 25:0 for opcodes 50 and 58.
- R7: Every compact branch and indirect jump raises forbidden_slot and clears has_delay_slot. A not-taken compact branch gives next_pc = PC + 4.
- R8: A compact branch that links raises link_we with link_value = PC + 4 only when taken. When no link is written, link_we and link_value are zero.
- R9: Opcodes 54 and 62 with rs number nonzero are taken when rs value == 0 (54) or != 0 (62). With rs number 0 they are always-taken jumps to rt value + sign-extended bits 15:0, unshifted. Opcode 62 then also links PC + 4.
- R10: Opcode 50 is always taken, and opcode 58 is always taken and links PC + 4, both with the 26-bit offset.
- R11: Opcodes 6 and 7 with legacy_mode high, or with rt number 0, are delayed branches on rs value <= 0 (6) or > 0 (7). They raise has_delay_slot. Taken, they go to PC + 4 + (sign-extended bits 15:0 << 2); not taken, they go to PC + 8.
- R12: With legacy_mode high, opcodes 22 and 23 are delayed branches on rs value <= 0 / > 0 that link PC + 8 when taken, and opcodes 8 and 24 make no transfer.
- R13: Opcode 17 with rs number 9 is a delayed branch taken when fpr_lsb is 0. With rs number 13 it is taken when fpr_lsb is 1. Other rs numbers make no transfer.
- R14: An instruction that makes no transfer gives taken = 0, next_pc = PC + 4 and no link, delay slot or forbidden slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | DW | Value of register rs |
| rt_val | input | DW | Value of register rt |
| fpr_lsb | input | 1 | Bit 0 of the floating-point register named by rt |
| pc | input | DW | Address of the instruction |
| legacy_mode | input | 1 | Select pre-compact meaning of overloaded opcodes |
| out_valid | output | 1 | Results below belong to the last accepted instruction |
| taken | output | 1 | Control transfer taken |
| next_pc | output | DW | Address of the next instruction to execute after this one (and its delay slot, if any) |
| link_we | output | 1 | Register 31 is written |
| link_value | output | DW | Value written to register 31, zero when none |
| has_delay_slot | output | 1 | Instruction is a delayed branch |
| forbidden_slot | output | 1 | Instruction is a compact branch or indirect jump |

## Verification
Every result of this block is due exactly one rising edge after the instruction is sampled, so taken, next_pc, link and slot flags all appear with out_valid in the following cycle. The bench drives each instruction at a falling edge and queues the expected record computed by its own model. A monitor pops that record at the next falling edge on which out_valid is high, so each comparison lands on the cycle the result is due and in instruction order. Overflow boundaries such as 0x7FFFFFFF + 1 and 0x80000000 + 0xFFFFFFFF are driven directly, alongside a randomized mix of all opcode groups and register-number relations.

// File: rtl/cbr_pkg.sv
// Shared types for the compact branch resolution unit.
// Assumes a 32-bit instruction word with opcode in bits 31:26.
package cbr_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REGN_W  = 5;
    localparam int OFFS_W  = 26;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REGN_W;
    localparam int RT_LSB  = RS_LSB - REGN_W;

    // Kind of control transfer an instruction performs
    typedef enum logic [1:0] {
        XF_NONE,
        XF_DELAYED,
        XF_COMPACT,
        XF_JUMP
    } xfer_e;

    // Condition evaluated on the operands
    typedef enum logic [4:0] {
        C_NEVER,
        C_ALWAYS,
        C_RS_LEZ,
        C_RS_GTZ,
        C_RT_LEZ,
        C_RT_GEZ,
        C_RT_GTZ,
        C_RT_LTZ,
        C_GEU,
        C_LTU,
        C_GES,
        C_LTS,
        C_OVF,
        C_NOVF,
        C_RT_EQZ,
        C_RT_NEZ,
        C_EQ,
        C_NE,
        C_RS_EQZ,
        C_RS_NEZ,
        C_FP_CLR,
        C_FP_SET
    } cond_e;

    // Which offset field forms the branch target
    typedef enum logic [1:0] {
        OFS_16,
        OFS_21,
        OFS_26
    } ofs_e;

    typedef struct packed {
        xfer_e xfer;
        cond_e cond;
        ofs_e  ofs;
        logic  link;
    } plan_t;

endpackage

// File: rtl/cbr_decode.sv
// Instruction classifier: maps opcode, register numbers and mode onto a
// transfer plan (kind, condition, offset field, link). Purely combinational.
// Assumes the opcode values given as parameters are distinct.
module cbr_decode
    import cbr_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_LEZ_GRP  = 6'd6,
    parameter logic [OPC_W-1:0] OP_GTZ_GRP  = 6'd7,
    parameter logic [OPC_W-1:0] OP_LEZL_GRP = 6'd22,
    parameter logic [OPC_W-1:0] OP_GTZL_GRP = 6'd23,
    parameter logic [OPC_W-1:0] OP_OVF_GRP  = 6'd8,
    parameter logic [OPC_W-1:0] OP_NOVF_GRP = 6'd24,
    parameter logic [OPC_W-1:0] OP_EQZ_GRP  = 6'd54,
    parameter logic [OPC_W-1:0] OP_NEZ_GRP  = 6'd62,
    parameter logic [OPC_W-1:0] OP_BR26     = 6'd50,
    parameter logic [OPC_W-1:0] OP_BRL26    = 6'd58,
    parameter logic [OPC_W-1:0] OP_FPU      = 6'd17,
    parameter logic [REGN_W-1:0] FP_SUB_CLR = 5'd9,
    parameter logic [REGN_W-1:0] FP_SUB_SET = 5'd13
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [REGN_W-1:0] rs_num,
    input  logic [REGN_W-1:0] rt_num,
    input  logic              legacy_mode,
    output plan_t             plan
);

    logic rs_zero, rt_zero, same_reg, rs_ge_rt, old_form;

    // Relations between the two register numbers that select variants
    always_comb begin
        rs_zero  = (rs_num == '0);
        rt_zero  = (rt_num == '0);
        same_reg = (rs_num == rt_num);
        rs_ge_rt = (rs_num >= rt_num);
        old_form = legacy_mode || rt_zero;
    end

    // Classification of the instruction into a transfer plan
    always_comb begin
        plan = '{xfer: XF_NONE, cond: C_NEVER, ofs: OFS_16, link: 1'b0};
        case (opcode)
            OP_LEZ_GRP: begin
                if (old_form) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_RS_LEZ;
                end else begin
                    plan.xfer = XF_COMPACT;
                    if (rs_zero) begin
                        plan.cond = C_RT_LEZ;
                        plan.link = 1'b1;
                    end else if (same_reg) begin
                        plan.cond = C_RT_GEZ;
                        plan.link = 1'b1;
                    end else begin
                        plan.cond = C_GEU;
                    end
                end
            end
            OP_GTZ_GRP: begin
                if (old_form) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_RS_GTZ;
                end else begin
                    plan.xfer = XF_COMPACT;
                    if (rs_zero) begin
                        plan.cond = C_RT_GTZ;
                        plan.link = 1'b1;
                    end else if (same_reg) begin
                        plan.cond = C_RT_LTZ;
                        plan.link = 1'b1;
                    end else begin
                        plan.cond = C_LTU;
                    end
                end
            end
            OP_LEZL_GRP: begin
                if (legacy_mode) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_RS_LEZ;
                    plan.link = 1'b1;
                end else if (!rt_zero) begin
                    plan.xfer = XF_COMPACT;
                    if (rs_zero)       plan.cond = C_RT_LEZ;
                    else if (same_reg) plan.cond = C_RT_GEZ;
                    else               plan.cond = C_GES;
                end
            end
            OP_GTZL_GRP: begin
                if (legacy_mode) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_RS_GTZ;
                    plan.link = 1'b1;
                end else if (!rt_zero) begin
                    plan.xfer = XF_COMPACT;
                    if (rs_zero)       plan.cond = C_RT_GTZ;
                    else if (same_reg) plan.cond = C_RT_LTZ;
                    else               plan.cond = C_LTS;
                end
            end
            OP_OVF_GRP: begin
                if (!legacy_mode) begin
                    plan.xfer = XF_COMPACT;
                    if (rs_ge_rt) begin
                        plan.cond = C_OVF;
                    end else if (rs_zero) begin
                        plan.cond = C_RT_EQZ;
                        plan.link = 1'b1;
                    end else begin
                        plan.cond = C_EQ;
                    end
                end
            end
            OP_NOVF_GRP: begin
                if (!legacy_mode) begin
                    plan.xfer = XF_COMPACT;
                    if (rs_ge_rt) begin
                        plan.cond = C_NOVF;
                    end else if (rs_zero) begin
                        plan.cond = C_RT_NEZ;
                        plan.link = 1'b1;
                    end else begin
                        plan.cond = C_NE;
                    end
                end
            end
            OP_EQZ_GRP: begin
                if (rs_zero) begin
                    plan.xfer = XF_JUMP;
                    plan.cond = C_ALWAYS;
                end else begin
                    plan.xfer = XF_COMPACT;
                    plan.cond = C_RS_EQZ;
                    plan.ofs  = OFS_21;
                end
            end
            OP_NEZ_GRP: begin
                if (rs_zero) begin
                    plan.xfer = XF_JUMP;
                    plan.cond = C_ALWAYS;
                    plan.link = 1'b1;
                end else begin
                    plan.xfer = XF_COMPACT;
                    plan.cond = C_RS_NEZ;
                    plan.ofs  = OFS_21;
                end
            end
            OP_BR26, OP_BRL26: begin
                plan.xfer = XF_COMPACT;
                plan.cond = C_ALWAYS;
                plan.ofs  = OFS_26;
                plan.link = (opcode == OP_BRL26);
            end
            OP_FPU: begin
                if (rs_num == FP_SUB_CLR) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_FP_CLR;
                end else if (rs_num == FP_SUB_SET) begin
                    plan.xfer = XF_DELAYED;
                    plan.cond = C_FP_SET;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cbr_cond.sv
// Condition evaluator: computes every operand test once and selects the
// one the plan names. Assumes two's-complement operands of DW bits.
module cbr_cond
    import cbr_pkg::*;
#(
    parameter int DW = 32
) (
    input  cond_e         cond,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rt_val,
    input  logic          fpr_lsb,
    output logic          cond_true
);

    localparam int MSB = DW - 1;

    logic          rs_neg, rt_neg, rs_z, rt_z;
    logic [DW-1:0] sum;
    logic          add_ovf, equal, geu, ges;

    // Sign, zero and relational flags shared by all conditions
    always_comb begin
        rs_neg  = rs_val[MSB];
        rt_neg  = rt_val[MSB];
        rs_z    = (rs_val == '0);
        rt_z    = (rt_val == '0);
        equal   = (rs_val == rt_val);
        geu     = (rs_val >= rt_val);
        ges     = ($signed(rs_val) >= $signed(rt_val));
        sum     = rs_val + rt_val;
        add_ovf = (rs_neg == rt_neg) && (sum[MSB] != rs_neg);
    end

    // Selection of the condition named by the plan
    always_comb begin
        case (cond)
            C_ALWAYS: cond_true = 1'b1;
            C_RS_LEZ: cond_true = rs_neg || rs_z;
            C_RS_GTZ: cond_true = !rs_neg && !rs_z;
            C_RT_LEZ: cond_true = rt_neg || rt_z;
            C_RT_GEZ: cond_true = !rt_neg;
            C_RT_GTZ: cond_true = !rt_neg && !rt_z;
            C_RT_LTZ: cond_true = rt_neg;
            C_GEU:    cond_true = geu;
            C_LTU:    cond_true = !geu;
            C_GES:    cond_true = ges;
            C_LTS:    cond_true = !ges;
            C_OVF:    cond_true = add_ovf;
            C_NOVF:   cond_true = !add_ovf;
            C_RT_EQZ: cond_true = rt_z;
            C_RT_NEZ: cond_true = !rt_z;
            C_EQ:     cond_true = equal;
            C_NE:     cond_true = !equal;
            C_RS_EQZ: cond_true = rs_z;
            C_RS_NEZ: cond_true = !rs_z;
            C_FP_CLR: cond_true = !fpr_lsb;
            C_FP_SET: cond_true = fpr_lsb;
            default:  cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
// Target and link generator: forms the three PC-relative targets, the
// indirect jump target and the sequential addresses, then picks next PC,
// link and slot flags from the plan and the evaluated condition.
// Assumes 4-byte instructions.
module cbr_target
    import cbr_pkg::*;
#(
    parameter int DW = 32
) (
    input  plan_t             plan,
    input  logic              cond_true,
    input  logic [DW-1:0]     pc,
    input  logic [DW-1:0]     rt_val,
    input  logic [OFFS_W-1:0] offs,
    output logic              taken,
    output logic [DW-1:0]     next_pc,
    output logic              link_we,
    output logic [DW-1:0]     link_value,
    output logic              has_delay_slot,
    output logic              forbidden_slot
);

    localparam int N_OFS      = 3;
    localparam int INSN_BYTES = 4;

    logic [DW-1:0] seq4, seq8, jump_tgt;
    logic [DW-1:0] rel_tgt [N_OFS];

    // Sequential successors and the unshifted indirect jump target
    always_comb begin
        seq4     = pc + DW'(INSN_BYTES);
        seq8     = pc + DW'(2 * INSN_BYTES);
        jump_tgt = rt_val + {{(DW-16){offs[15]}}, offs[15:0]};
    end

    // One PC-relative adder per offset width
    for (genvar g = 0; g < N_OFS; g++) begin : g_rel
        localparam int W = (g == 0) ? 16 : ((g == 1) ? 21 : 26);
        logic [DW-1:0] ext;
        always_comb begin
            ext        = {{(DW-W){offs[W-1]}}, offs[W-1:0]};
            rel_tgt[g] = seq4 + (ext << 2);
        end
    end

    // Final selection of transfer results
    always_comb begin
        taken          = (plan.xfer != XF_NONE) && cond_true;
        has_delay_slot = (plan.xfer == XF_DELAYED);
        forbidden_slot = (plan.xfer == XF_COMPACT) || (plan.xfer == XF_JUMP);
        link_we        = plan.link && taken;
        link_value     = '0;
        if (link_we) link_value = has_delay_slot ? seq8 : seq4;
        case (plan.xfer)
            XF_DELAYED: next_pc = taken ? rel_tgt[0] : seq8;
            XF_COMPACT: begin
                if (!taken)                   next_pc = seq4;
                else if (plan.ofs == OFS_26)  next_pc = rel_tgt[2];
                else if (plan.ofs == OFS_21)  next_pc = rel_tgt[1];
                else                          next_pc = rel_tgt[0];
            end
            XF_JUMP:    next_pc = jump_tgt;
            default:    next_pc = seq4;
        endcase
    end

endmodule

// File: rtl/cbr_unit.sv
// Compact branch resolution unit (top). Decodes one instruction per cycle,
// evaluates its condition, and registers taken, next PC, link and slot
// flags; results appear one cycle after in_valid. Assumes operands are
// already read from the register files.
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [OPC_W-1:0] OP_LEZ_GRP  = 6'd6,
    parameter logic [OPC_W-1:0] OP_GTZ_GRP  = 6'd7,
    parameter logic [OPC_W-1:0] OP_LEZL_GRP = 6'd22,
    parameter logic [OPC_W-1:0] OP_GTZL_GRP = 6'd23,
    parameter logic [OPC_W-1:0] OP_OVF_GRP  = 6'd8,
    parameter logic [OPC_W-1:0] OP_NOVF_GRP = 6'd24,
    parameter logic [OPC_W-1:0] OP_EQZ_GRP  = 6'd54,
    parameter logic [OPC_W-1:0] OP_NEZ_GRP  = 6'd62,
    parameter logic [OPC_W-1:0] OP_BR26     = 6'd50,
    parameter logic [OPC_W-1:0] OP_BRL26    = 6'd58,
    parameter logic [OPC_W-1:0] OP_FPU      = 6'd17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] instr,
    input  logic [DW-1:0]     rs_val,
    input  logic [DW-1:0]     rt_val,
    input  logic              fpr_lsb,
    input  logic [DW-1:0]     pc,
    input  logic              legacy_mode,
    output logic              out_valid,
    output logic              taken,
    output logic [DW-1:0]     next_pc,
    output logic              link_we,
    output logic [DW-1:0]     link_value,
    output logic              has_delay_slot,
    output logic              forbidden_slot
);

    plan_t         plan;
    logic          cond_true;
    logic          c_taken, c_link_we, c_dly, c_fbd;
    logic [DW-1:0] c_next, c_link;

    cbr_decode #(
        .OP_LEZ_GRP (OP_LEZ_GRP),  .OP_GTZ_GRP (OP_GTZ_GRP),
        .OP_LEZL_GRP(OP_LEZL_GRP), .OP_GTZL_GRP(OP_GTZL_GRP),
        .OP_OVF_GRP (OP_OVF_GRP),  .OP_NOVF_GRP(OP_NOVF_GRP),
        .OP_EQZ_GRP (OP_EQZ_GRP),  .OP_NEZ_GRP (OP_NEZ_GRP),
        .OP_BR26    (OP_BR26),     .OP_BRL26   (OP_BRL26),
        .OP_FPU     (OP_FPU)
    ) u_dec (
        .opcode     (instr[OPC_LSB +: OPC_W]),
        .rs_num     (instr[RS_LSB +: REGN_W]),
        .rt_num     (instr[RT_LSB +: REGN_W]),
        .legacy_mode(legacy_mode),
        .plan       (plan)
    );

    cbr_cond #(.DW(DW)) u_cond (
        .cond     (plan.cond),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .fpr_lsb  (fpr_lsb),
        .cond_true(cond_true)
    );

    cbr_target #(.DW(DW)) u_tgt (
        .plan          (plan),
        .cond_true     (cond_true),
        .pc            (pc),
        .rt_val        (rt_val),
        .offs          (instr[OFFS_W-1:0]),
        .taken         (c_taken),
        .next_pc       (c_next),
        .link_we       (c_link_we),
        .link_value    (c_link),
        .has_delay_slot(c_dly),
        .forbidden_slot(c_fbd)
    );

    // Result register: capture on in_valid, valid strobe follows in_valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            taken          <= 1'b0;
            next_pc        <= '0;
            link_we        <= 1'b0;
            link_value     <= '0;
            has_delay_slot <= 1'b0;
            forbidden_slot <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                taken          <= c_taken;
                next_pc        <= c_next;
                link_we        <= c_link_we;
                link_value     <= c_link;
                has_delay_slot <= c_dly;
                forbidden_slot <= c_fbd;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    compact_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && forbidden_slot && !taken) |-> (next_pc == $past(pc) + DW'(4)));

    // R7
    slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(has_delay_slot && forbidden_slot));

    // R8
    compact_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_we && forbidden_slot) |-> (link_value == $past(pc) + DW'(4)));

    // R8
    link_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_we) |-> taken);

    // R11
    delayed_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && has_delay_slot && !taken) |-> (next_pc == $past(pc) + DW'(8)));

    // R12
    delayed_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_we && has_delay_slot) |-> (link_value == $past(pc) + DW'(8)));

endmodule

// File: tb/sim_cbr_unit.sv
// Scoreboard bench: a driver task queues the expected record from an
// independent model; a monitor compares it when out_valid is seen.
module sim_cbr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        fpr_lsb = 1'b0;
    logic [31:0] pc = '0;
    logic        legacy_mode = 1'b0;
    logic        out_valid, taken, link_we, has_delay_slot, forbidden_slot;
    logic [31:0] next_pc, link_value;

    cbr_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .fpr_lsb(fpr_lsb), .pc(pc),
        .legacy_mode(legacy_mode), .out_valid(out_valid), .taken(taken),
        .next_pc(next_pc), .link_we(link_we), .link_value(link_value),
        .has_delay_slot(has_delay_slot), .forbidden_slot(forbidden_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          tk;
        logic [31:0] nxt;
        bit          lwe;
        logic [31:0] lval;
        bit          dly;
        bit          fbd;
        int          tag;
    } exp_t;

    exp_t sbq[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // Compact outcome: forbidden slot, PC+4 fallthrough, PC+4 link if taken
    function automatic void mdl_compact(inout exp_t e, input bit c,
                                        input logic [31:0] tgt, input bit lk,
                                        input logic [31:0] cur);
        e.fbd = 1'b1;
        e.tk  = c;
        e.nxt = c ? tgt : cur + 32'd4;
        if (c && lk) begin
            e.lwe  = 1'b1;
            e.lval = cur + 32'd4;
        end
    endfunction

    // Delayed outcome: delay slot, PC+8 fallthrough, PC+8 link if taken
    function automatic void mdl_delayed(inout exp_t e, input bit c,
                                        input logic [31:0] tgt, input bit lk,
                                        input logic [31:0] cur);
        e.dly = 1'b1;
        e.tk  = c;
        e.nxt = c ? tgt : cur + 32'd8;
        if (c && lk) begin
            e.lwe  = 1'b1;
            e.lval = cur + 32'd8;
        end
    endfunction

    // Reference model built from the requirement text
    function automatic exp_t model(logic [31:0] ins, logic [31:0] a,
                                   logic [31:0] b, bit fp,
                                   logic [31:0] cur, bit leg);
        exp_t        e;
        int          op, rsn, rtn;
        longint      sa, sb, ssum;
        bit          ov;
        logic [31:0] t16, t21, t26;
        op  = int'(ins[31:26]);
        rsn = int'(ins[25:21]);
        rtn = int'(ins[20:16]);
        sa  = longint'($signed(a));
        sb  = longint'($signed(b));
        ssum = sa + sb;
        ov  = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
        t16 = cur + 32'd4 + ({{16{ins[15]}}, ins[15:0]} << 2);
        t21 = cur + 32'd4 + ({{11{ins[20]}}, ins[20:0]} << 2);
        t26 = cur + 32'd4 + ({{6{ins[25]}}, ins[25:0]} << 2);
        e = '{tk: 0, nxt: cur + 32'd4, lwe: 0, lval: 32'd0, dly: 0, fbd: 0, tag: 14};
        case (op)
            6: if (leg || rtn == 0) begin e.tag = 11; mdl_delayed(e, sa <= 0, t16, 0, cur); end   // R11
               else begin
                   e.tag = 2;  // R2
                   if (rsn == 0)        mdl_compact(e, sb <= 0, t16, 1, cur);
                   else if (rsn == rtn) mdl_compact(e, sb >= 0, t16, 1, cur);
                   else                 mdl_compact(e, a >= b, t16, 0, cur);
               end
            7: if (leg || rtn == 0) begin e.tag = 11; mdl_delayed(e, sa > 0, t16, 0, cur); end
               else begin
                   e.tag = 2;
                   if (rsn == 0)        mdl_compact(e, sb > 0, t16, 1, cur);
                   else if (rsn == rtn) mdl_compact(e, sb < 0, t16, 1, cur);
                   else                 mdl_compact(e, a < b, t16, 0, cur);
               end
            22: if (leg) begin e.tag = 12; mdl_delayed(e, sa <= 0, t16, 1, cur); end   // R12
                else begin
                    e.tag = 3;  // R3
                    if (rtn != 0) begin
                        if (rsn == 0)        mdl_compact(e, sb <= 0, t16, 0, cur);
                        else if (rsn == rtn) mdl_compact(e, sb >= 0, t16, 0, cur);
                        else                 mdl_compact(e, sa >= sb, t16, 0, cur);
                    end
                end
            23: if (leg) begin e.tag = 12; mdl_delayed(e, sa > 0, t16, 1, cur); end
                else begin
                    e.tag = 3;
                    if (rtn != 0) begin
                        if (rsn == 0)        mdl_compact(e, sb > 0, t16, 0, cur);
                        else if (rsn == rtn) mdl_compact(e, sb < 0, t16, 0, cur);
                        else                 mdl_compact(e, sa < sb, t16, 0, cur);
                    end
                end
            8:  if (leg) e.tag = 12;
                else if (rsn >= rtn) begin e.tag = 4; mdl_compact(e, ov, t16, 0, cur); end    // R4
                else begin
                    e.tag = 5;  // R5
                    if (rsn == 0) mdl_compact(e, b == 0, t16, 1, cur);
                    else          mdl_compact(e, a == b, t16, 0, cur);
                end
            24: if (leg) e.tag = 12;
                else if (rsn >= rtn) begin e.tag = 4; mdl_compact(e, !ov, t16, 0, cur); end
                else begin
                    e.tag = 5;
                    if (rsn == 0) mdl_compact(e, b != 0, t16, 1, cur);
                    else          mdl_compact(e, a != b, t16, 0, cur);
                end
            54, 62: begin
                e.tag = 9;  // R9
                if (rsn != 0) mdl_compact(e, (op == 54) ? (a == 0) : (a != 0), t21, 0, cur);
                else begin
                    e.fbd = 1'b1;
                    e.tk  = 1'b1;
                    e.nxt = b + {{16{ins[15]}}, ins[15:0]};
                    if (op == 62) begin
                        e.lwe  = 1'b1;
                        e.lval = cur + 32'd4;
                    end
                end
            end
            50: begin e.tag = 10; mdl_compact(e, 1, t26, 0, cur); end  // R10
            58: begin e.tag = 10; mdl_compact(e, 1, t26, 1, cur); end
            17: begin
                e.tag = 13;  // R13
                if (rsn == 9)       mdl_delayed(e, !fp, t16, 0, cur);
                else if (rsn == 13) mdl_delayed(e, fp, t16, 0, cur);
            end
            default: e.tag = 14;  // R14
        endcase
        return e;
    endfunction

    // Driver: present one instruction at a falling edge and queue its record
    task automatic issue(int tag, logic [31:0] ins, logic [31:0] a,
                         logic [31:0] b, bit fp, logic [31:0] cur, bit leg);
        exp_t e;
        @(negedge clk);
        in_valid    = 1'b1;
        instr       = ins;
        rs_val      = a;
        rt_val      = b;
        fpr_lsb     = fp;
        pc          = cur;
        legacy_mode = leg;
        e = model(ins, a, b, fp, cur, leg);
        if (tag != 0) e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk16(int op, int rsn, int rtn, logic [15:0] im);
        return {op[5:0], rsn[4:0], rtn[4:0], im};
    endfunction

    function automatic logic [31:0] mk21(int op, int rsn, logic [20:0] im);
        return {op[5:0], rsn[4:0], im};
    endfunction

    function automatic logic [31:0] mk26(int op, logic [25:0] im);
        return {op[5:0], im};
    endfunction

    // Monitor: compare each produced result with the oldest queued record
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            bit   bad;
            n_run++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
            end else begin
                e = sbq.pop_front();
                bad = 1'b0;
                if (taken !== e.tk) begin
                    bad = 1'b1;
                    $display("FAIL R%0d taken: actual %0b expected %0b", e.tag, taken, e.tk);
                end
                if (next_pc !== e.nxt) begin
                    bad = 1'b1;
                    $display("FAIL R%0d next_pc: actual %08h expected %08h", e.tag, next_pc, e.nxt);
                end
                if (link_we !== e.lwe || link_value !== e.lval) begin
                    bad = 1'b1;
                    $display("FAIL R%0d link: actual %0b/%08h expected %0b/%08h",
                             e.tag, link_we, link_value, e.lwe, e.lval);
                end
                if (has_delay_slot !== e.dly || forbidden_slot !== e.fbd) begin
                    bad = 1'b1;
                    $display("FAIL R%0d slots dly/fbd: actual %0b/%0b expected %0b/%0b",
                             e.tag, has_delay_slot, forbidden_slot, e.dly, e.fbd);
                end
                if (bad) n_fail++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Local reset-state check of all outputs
    task automatic check_idle(string what);
        n_run++;
        if (out_valid !== 1'b0 || taken !== 1'b0 || next_pc !== '0 || link_we !== 1'b0 ||
            link_value !== '0 || has_delay_slot !== 1'b0 || forbidden_slot !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 %s: actual v=%0b t=%0b pc=%08h expected all zero",
                     what, out_valid, taken, next_pc);
        end
    endtask

    initial begin
        logic [31:0] base;
        base = 32'h0040_1000;
        repeat (3) @(negedge clk);
        check_idle("reset state");  // R1
        @(negedge clk);
        rst_n = 1'b1;

        // R2: link and unsigned variants
        issue(2, mk16(6, 0, 5, 16'h0010), 32'h0, 32'h0, 0, base, 0);
        issue(2, mk16(6, 5, 5, 16'h0010), 32'h0, 32'hFFFF_FFFF, 0, base, 0);
        issue(2, mk16(6, 3, 5, 16'h0020), 32'hFFFF_FFFF, 32'h1, 0, base, 0);
        issue(2, mk16(7, 3, 5, 16'h0020), 32'hFFFF_FFFF, 32'h1, 0, base, 0);
        issue(2, mk16(7, 5, 5, 16'h0004), 32'h0, 32'h8000_0000, 0, base, 0);
        // R3: signed compare, no link, rt number zero gives nothing
        issue(3, mk16(22, 3, 5, 16'h0008), 32'hFFFF_FFFB, 32'h2, 0, base, 0);
        issue(3, mk16(23, 3, 5, 16'h0008), 32'hFFFF_FFFB, 32'h2, 0, base, 0);
        issue(3, mk16(22, 0, 4, 16'h0008), 32'h5, 32'h0, 0, base, 0);
        issue(3, mk16(23, 4, 0, 16'h0008), 32'h5, 32'h1, 0, base, 0);
        // R4: overflow boundaries
        issue(4, mk16(8, 5, 3, 16'h0040), 32'h7FFF_FFFF, 32'h1, 0, base, 0);
        issue(4, mk16(24, 5, 3, 16'h0040), 32'h7FFF_FFFF, 32'h1, 0, base, 0);
        issue(4, mk16(8, 5, 3, 16'h0040), 32'h8000_0000, 32'hFFFF_FFFF, 0, base, 0);
        issue(4, mk16(8, 5, 3, 16'h0040), 32'h7FFF_FFFF, 32'h8000_0000, 0, base, 0);
        issue(4, mk16(24, 5, 3, 16'h0040), 32'h0, 32'h7FFF_FFFF, 0, base, 0);
        issue(4, mk16(8, 4, 4, 16'h0040), 32'h4000_0000, 32'h4000_0000, 0, base, 0);
        issue(4, mk16(24, 0, 0, 16'h0040), 32'h0, 32'h0, 0, base, 0);
        // R5: equality forms
        issue(5, mk16(8, 0, 4, 16'h0003), 32'h9, 32'h0, 0, base, 0);
        issue(5, mk16(24, 2, 4, 16'h0003), 32'h77, 32'h77, 0, base, 0);
        issue(5, mk16(24, 0, 4, 16'h0003), 32'h0, 32'h1, 0, base, 0);
        // R6: negative 16-bit offset on a taken equality branch
        issue(6, mk16(8, 2, 4, 16'h8000), 32'h5, 32'h5, 0, 32'h0010_0000, 0);
        // R7: not-taken compact falls through with forbidden slot
        issue(7, mk16(22, 0, 6, 16'h0100), 32'h0, 32'h1, 0, base, 0);
        // R8: not-taken linking compact writes no link
        issue(8, mk16(7, 0, 6, 16'h0100), 32'h0, 32'hFFFF_FFF0, 0, base, 0);
        // R9: 21-bit zero tests and indirect jumps
        issue(9, mk21(54, 3, 21'h1F_FFF0), 32'h0, 32'h0, 0, base, 0);
        issue(9, mk21(62, 3, 21'h0F_0000), 32'h1, 32'h0, 0, base, 0);
        issue(9, mk16(54, 0, 7, 16'hFFFC), 32'h0, 32'h0000_2000, 0, base, 0);
        issue(9, mk16(62, 0, 7, 16'h0006), 32'h0, 32'h0000_2000, 0, base, 0);
        // R10: 26-bit unconditional forms
        issue(10, mk26(50, 26'h3FF_FFFF), 32'h0, 32'h0, 0, base, 0);
        issue(10, mk26(58, 26'h200_0000), 32'h0, 32'h0, 0, 32'h1000_0000, 0);
        // R11: delayed fallback by mode and by rt number zero
        issue(11, mk16(6, 4, 7, 16'h0010), 32'h0, 32'h3, 0, base, 1);
        issue(11, mk16(6, 4, 0, 16'h0010), 32'h1, 32'h3, 0, base, 0);
        issue(11, mk16(7, 4, 0, 16'hFFF0), 32'h1, 32'h0, 0, base, 0);
        // R12: legacy linking delayed and empty overflow opcodes
        issue(12, mk16(22, 4, 1, 16'h0010), 32'hFFFF_FFFF, 32'h0, 0, base, 1);
        issue(12, mk16(23, 4, 1, 16'h0010), 32'h0, 32'h0, 0, base, 1);
        issue(12, mk16(8, 5, 3, 16'h0010), 32'h7FFF_FFFF, 32'h1, 0, base, 1);
        // R13: floating-point bit branches
        issue(13, mk16(17, 9, 2, 16'h0020), 32'h0, 32'h0, 0, base, 0);
        issue(13, mk16(17, 13, 2, 16'h0020), 32'h0, 32'h0, 0, base, 0);
        issue(13, mk16(17, 8, 2, 16'h0020), 32'h0, 32'h0, 1, base, 0);
        // R14: unrelated opcode
        issue(14, mk16(9, 3, 5, 16'h1234), 32'h0, 32'h0, 0, base, 0);
        idle();
        idle();
        check_idle_valid();

        // Randomized mix over all groups and register-number relations
        for (int i = 0; i < N_RANDOM; i++) begin
            int          op, rsn, rtn, pick;
            logic [31:0] a, b, ins;
            int          ops[12] = '{6, 7, 22, 23, 8, 24, 54, 62, 50, 58, 17, 9};
            op   = ops[$urandom_range(0, 11)];
            pick = $urandom_range(0, 3);
            rsn  = (pick == 0) ? 0 : $urandom_range(0, 31);
            rtn  = (pick == 1) ? 0 : ((pick == 2) ? rsn : $urandom_range(0, 31));
            if (op == 17) rsn = ($urandom_range(0, 1) == 1) ? 9 : 13;
            case ($urandom_range(0, 4))
                0: a = 32'h7FFF_FFFF;
                1: a = 32'h8000_0000;
                2: a = 32'h0;
                default: a = $urandom;
            endcase
            b = ($urandom_range(0, 3) == 0) ? a : (($urandom_range(0, 3) == 0) ? 32'h0 : $urandom);
            ins = {op[5:0], rsn[4:0], rtn[4:0], 16'($urandom)};
            issue(0, ins, a, b, 1'($urandom), {$urandom} & 32'hFFFF_FFFC, 1'($urandom));
        end
        idle();
        idle();
        n_run++;
        if (sbq.size() != 0) begin  // R1
            n_fail++;
            $display("FAIL R1 pending results: actual %0d expected 0", sbq.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // R1: valid strobe drops after idle cycles
    task automatic check_idle_valid();
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 out_valid after idle: actual %0b expected 0", out_valid);
        end
    endtask

endmodule